// File: doc/BRIEF.md
# SIMD Pixel Processing Node

This block is a single processing element of a focal-plane image processor array. Every node in the array receives the same broadcast instruction word in the same cycle and updates its state on the same clock edge. The node holds an 8-bit arithmetic/logic/shift unit, a 16-bit multiply-accumulator, eight general registers and a 64-word local store. It has one outgoing neighbour register and reads the outgoing registers of its north, east, west and south neighbours.

A capture instruction freezes the 16 attached detector channels in the cycle it issues. It then copies them into local words 0 to 15 over the next 16 cycles while `busy` is high. Other instructions keep executing during that copy. An instruction is 18 bits: opcode in [17:14], destination register in [13:11], source register in [10:8], and immediate or address in [7:0].

Top module: `simd_pixel_node`

## Requirements
- R1: Opcode 0 loads the immediate into rd. Opcode 1 sets rd to rd+rs and opcode 2 sets rd to rd-rs, both modulo 256.
- R2: Opcodes 3, 4 and 5 set rd to rd AND rs, rd OR rs and rd XOR rs respectively.
- R3: Opcode 6 shifts rd by imm[2:0] places, left when imm[3]=0 and logically right when imm[3]=1.
- R4: Opcode 9 adds the unsigned product rd*rs to the 16-bit accumulator modulo 65536, and opcode 10 clears the accumulator. Opcodes 11 and 12 copy the accumulator's high byte and low byte into rd.
- R5: Opcode 8 stores rs at address imm and opcode 7 loads the word at imm into rd. Addresses 64 to 255 read as zero, and stores to them change no word.
- R6: Opcode 13 loads rs into `news_out`. Opcode 14 loads rd with the neighbour value selected by imm[1:0] (0 north, 1 east, 2 west, 3 south), or with zero when that direction's bit of `nbr_present` is low.
- R7: Opcode 15, issued while idle, captures all 16 channels at its own clock edge. Channel i sits at `det_data[8i+7:8i]`, and later changes on `det_data` do not affect the capture. `busy` is high for exactly 16 cycles after that edge, and channel i reaches word i at the i+1-th edge.
- R8: Opcode 15 issued while `busy` is high is ignored: neither the snapshot nor the busy window changes.
- R9: Instructions other than opcode 15 execute normally while `busy` is high. A store that hits the word being copied in the same cycle keeps the stored value.
- R10: After reset the registers, accumulator, `news_out`, every memory word and `busy` are zero.
- R11: While `instr_valid` is low, no register, accumulator, memory or `news_out` state changes, and no capture starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all nodes |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Broadcast instruction is valid this cycle |
| instr | input | 18 | Broadcast instruction word |
| det_data | input | 128 | Digitised detector channels, 8 bits each |
| nbr_present | input | 4 | Neighbour exists: bit0 N, bit1 E, bit2 W, bit3 S |
| nbr_n_in | input | 8 | North neighbour's outgoing register |
| nbr_e_in | input | 8 | East neighbour's outgoing register |
| nbr_w_in | input | 8 | West neighbour's outgoing register |
| nbr_s_in | input | 8 | South neighbour's outgoing register |
| news_out | output | 8 | This node's outgoing neighbour register |
| acc_out | output | 16 | Accumulator value |
| busy | output | 1 | Capture copy in progress |

## Verification
The background copy of a capture into local memory and an instruction-driven store can land in the same cycle, and both can target the same word. The bench issues a capture and then lets the copy run while it executes a register load, a second capture and a store to word 10. The store is timed for the edge at which the copy writes word 10. Afterwards every word from 0 to 15 is read back through a load and an outgoing-register write. Word 10 must hold the stored value, and every other word must hold the channel value frozen at the first capture.

// File: rtl/snode_pkg.sv
`timescale 1ns/1ps
package snode_pkg;
    localparam int OPC_W    = 4;
    localparam int NBR_DIRS = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LDI  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SHF  = 4'd6,
        OP_LD   = 4'd7,
        OP_ST   = 4'd8,
        OP_MAC  = 4'd9,
        OP_MCLR = 4'd10,
        OP_MVH  = 4'd11,
        OP_MVL  = 4'd12,
        OP_NWR  = 4'd13,
        OP_NRD  = 4'd14,
        OP_SMP  = 4'd15
    } snode_op_e;
endpackage

// File: rtl/snode_alu.sv
`timescale 1ns/1ps
module snode_alu import snode_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  snode_op_e          op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [3:0]         shctl,
    output logic [DATA_W-1:0]  y
);
    always_comb begin
        y = a;
        unique case (op)
            OP_ADD: y = a + b;
            OP_SUB: y = a - b;
            OP_AND: y = a & b;
            OP_OR:  y = a | b;
            OP_XOR: y = a ^ b;
            OP_SHF: y = shctl[3] ? (a >> shctl[2:0]) : (a << shctl[2:0]);
            default: y = a;
        endcase
    end
endmodule

// File: rtl/snode_mac.sv
`timescale 1ns/1ps
module snode_mac #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic              en,
    input  logic              clr,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [ACC_W-1:0]  acc_q,
    output logic [ACC_W-1:0]  acc_d
);
    logic [ACC_W-1:0] prod;

    assign prod = ACC_W'(a) * ACC_W'(b);

    always_comb begin
        if (clr)
            acc_d = '0;
        else if (en)
            acc_d = acc_q + prod;
        else
            acc_d = acc_q;
    end
endmodule

// File: rtl/snode_lmem.sv
`timescale 1ns/1ps
module snode_lmem #(
    parameter int DATA_W = 8,
    parameter int WORDS  = 64,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata
);
    logic [WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    function automatic logic in_range(input logic [ADDR_W-1:0] addr);
        return int'(addr) < WORDS;
    endfunction

    assign rd_data = in_range(rd_addr) ? mem_q[rd_addr[IDX_W-1:0]] : '0;

    // port b is the capture copy; port a (instruction store) is applied last and wins
    always_comb begin
        mem_d = mem_q;
        if (b_we && in_range(b_addr))
            mem_d[b_addr[IDX_W-1:0]] = b_wdata;
        if (a_we && in_range(a_addr))
            mem_d[a_addr[IDX_W-1:0]] = a_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mem_q <= '0;
        else
            mem_q <= mem_d;
    end
endmodule

// File: rtl/snode_sampler.sv
`timescale 1ns/1ps
module snode_sampler #(
    parameter int DATA_W   = 8,
    parameter int CHANNELS = 16,
    parameter int ADDR_W   = 8,
    localparam int IDX_W   = $clog2(CHANNELS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CHANNELS*DATA_W-1:0] det_data,
    output logic                       busy,
    output logic                       wr_en,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data
);
    typedef struct packed {
        logic                             busy;
        logic [IDX_W-1:0]                 idx;
        logic [CHANNELS-1:0][DATA_W-1:0]  snap;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.idx == IDX_W'(CHANNELS - 1))
                s_d.busy = 1'b0;
            else
                s_d.idx = s_q.idx + 1'b1;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
            s_d.snap = det_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign wr_en   = s_q.busy;
    assign wr_addr = ADDR_W'(s_q.idx);
    assign wr_data = s_q.snap[s_q.idx];
endmodule

// File: rtl/simd_pixel_node.sv
`timescale 1ns/1ps
module simd_pixel_node import snode_pkg::*; #(
    parameter int DATA_W    = 8,
    parameter int REGS      = 8,
    parameter int MEM_WORDS = 64,
    parameter int ADDR_W    = 8,
    parameter int CHANNELS  = 16,
    localparam int RIDX_W   = $clog2(REGS),
    localparam int ACC_W    = 2 * DATA_W,
    localparam int INSTR_W  = OPC_W + 2 * RIDX_W + ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       instr_valid,
    input  logic [INSTR_W-1:0]         instr,
    input  logic [CHANNELS*DATA_W-1:0] det_data,
    input  logic [NBR_DIRS-1:0]        nbr_present,
    input  logic [DATA_W-1:0]          nbr_n_in,
    input  logic [DATA_W-1:0]          nbr_e_in,
    input  logic [DATA_W-1:0]          nbr_w_in,
    input  logic [DATA_W-1:0]          nbr_s_in,
    output logic [DATA_W-1:0]          news_out,
    output logic [ACC_W-1:0]           acc_out,
    output logic                       busy
);
    typedef struct packed {
        logic [REGS-1:0][DATA_W-1:0] rf;
        logic [ACC_W-1:0]            acc;
        logic [DATA_W-1:0]           nout;
    } core_t;

    core_t s_d, s_q;

    // instruction fields
    snode_op_e         op;
    logic [RIDX_W-1:0] rd, rs;
    logic [ADDR_W-1:0] imm;

    assign op  = snode_op_e'(instr[INSTR_W-1 -: OPC_W]);
    assign rd  = instr[ADDR_W + 2*RIDX_W - 1 -: RIDX_W];
    assign rs  = instr[ADDR_W + RIDX_W - 1 -: RIDX_W];
    assign imm = instr[ADDR_W-1:0];

    logic [DATA_W-1:0] opa, opb;
    assign opa = s_q.rf[rd];
    assign opb = s_q.rf[rs];

    // neighbour inputs, zeroed per missing direction
    logic [NBR_DIRS-1:0][DATA_W-1:0] nbr_raw, nbr_gated;
    logic [DATA_W-1:0]               nbr_sel;

    assign nbr_raw = {nbr_s_in, nbr_w_in, nbr_e_in, nbr_n_in};

    for (genvar g = 0; g < NBR_DIRS; g++) begin : g_nbr
        assign nbr_gated[g] = nbr_present[g] ? nbr_raw[g] : '0;
    end

    assign nbr_sel = nbr_gated[imm[1:0]];

    // functional units
    logic [DATA_W-1:0] alu_y;
    logic [ACC_W-1:0]  mac_acc_d;
    logic [DATA_W-1:0] mem_rd_data;
    logic              smp_wr_en;
    logic [ADDR_W-1:0] smp_wr_addr;
    logic [DATA_W-1:0] smp_wr_data;

    snode_alu #(.DATA_W(DATA_W)) i_alu (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .shctl (imm[3:0]),
        .y     (alu_y)
    );

    snode_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_mac (
        .en    (instr_valid && op == OP_MAC),
        .clr   (instr_valid && op == OP_MCLR),
        .a     (opa),
        .b     (opb),
        .acc_q (s_q.acc),
        .acc_d (mac_acc_d)
    );

    snode_sampler #(.DATA_W(DATA_W), .CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) i_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (instr_valid && op == OP_SMP),
        .det_data (det_data),
        .busy     (busy),
        .wr_en    (smp_wr_en),
        .wr_addr  (smp_wr_addr),
        .wr_data  (smp_wr_data)
    );

    snode_lmem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (imm),
        .rd_data (mem_rd_data),
        .a_we    (instr_valid && op == OP_ST),
        .a_addr  (imm),
        .a_wdata (opb),
        .b_we    (smp_wr_en),
        .b_addr  (smp_wr_addr),
        .b_wdata (smp_wr_data)
    );

    always_comb begin
        s_d     = s_q;
        s_d.acc = mac_acc_d;
        if (instr_valid) begin
            case (op)
                OP_LDI:  s_d.rf[rd] = DATA_W'(imm);
                OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHF:
                         s_d.rf[rd] = alu_y;
                OP_LD:   s_d.rf[rd] = mem_rd_data;
                OP_MVH:  s_d.rf[rd] = s_q.acc[ACC_W-1 -: DATA_W];
                OP_MVL:  s_d.rf[rd] = s_q.acc[DATA_W-1:0];
                OP_NWR:  s_d.nout   = opb;
                OP_NRD:  s_d.rf[rd] = nbr_sel;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign news_out = s_q.nout;
    assign acc_out  = s_q.acc;
endmodule

// File: rtl/snode_checker.sv
`timescale 1ns/1ps
module snode_checker import snode_pkg::*; #(
    parameter int CHANNELS = 16,
    parameter int DATA_W   = 8,
    parameter int ACC_W    = 16,
    localparam int CNT_W   = $clog2(CHANNELS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [OPC_W-1:0]  op,
    input logic              busy,
    input logic [ACC_W-1:0]  acc_out,
    input logic [DATA_W-1:0] news_out
);
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (busy)
            busy_cnt <= busy_cnt + 1'b1;
        else
            busy_cnt <= '0;
    end

    p_smp_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_SMP && !busy) |=> busy);

    p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CNT_W'(CHANNELS)));

    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == CNT_W'(CHANNELS - 1)) |=> !busy);

    p_mac_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_MCLR) |=> (acc_out == '0));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(acc_out) && $stable(news_out)));

    p_idle_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !busy) |=> !busy);
endmodule

bind simd_pixel_node snode_checker #(
    .CHANNELS (CHANNELS),
    .DATA_W   (DATA_W),
    .ACC_W    (ACC_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .op          (instr[INSTR_W-1 -: OPC_W]),
    .busy        (busy),
    .acc_out     (acc_out),
    .news_out    (news_out)
);

// File: tb/test_simd_pixel_node.sv
`timescale 1ns/1ps
module test_simd_pixel_node;
    import snode_pkg::*;

    localparam int IW = 18;
    localparam int NV = 53;

    typedef struct packed {
        logic [IW-1:0] ins;
        logic          chk;
        logic [7:0]    en;
        logic [15:0]   ea;
        logic [3:0]    req;
    } vec_t;

    function automatic logic [IW-1:0] mk(snode_op_e op, int rd, int rs, int imm);
        return {op, 3'(rd), 3'(rs), 8'(imm)};
    endfunction

    function automatic vec_t ex(snode_op_e op, int rd, int rs, int imm);
        return '{mk(op, rd, rs, imm), 1'b0, 8'h00, 16'h0000, 4'd0};
    endfunction

    function automatic vec_t cn(int rs, logic [7:0] en, logic [15:0] ea, int req);
        return '{mk(OP_NWR, 0, rs, 0), 1'b1, en, ea, 4'(req)};
    endfunction

    localparam vec_t VEC [NV] = '{
        ex(OP_LDI, 1, 0, 8'hC8), ex(OP_LDI, 2, 0, 8'h64),
        ex(OP_ADD, 1, 2, 0),     cn(1, 8'h2C, 16'h0000, 1),   // R1 wrap add
        ex(OP_SUB, 2, 1, 0),     cn(2, 8'h38, 16'h0000, 1),   // R1
        ex(OP_LDI, 3, 0, 8'h05), ex(OP_SUB, 3, 2, 0),
        cn(3, 8'hCD, 16'h0000, 1),                            // R1 wrap sub
        ex(OP_LDI, 4, 0, 8'hF0), ex(OP_LDI, 5, 0, 8'h3C),
        ex(OP_AND, 4, 5, 0),     cn(4, 8'h30, 16'h0000, 2),   // R2
        ex(OP_LDI, 4, 0, 8'hF0), ex(OP_XOR, 4, 5, 0),
        cn(4, 8'hCC, 16'h0000, 2),                            // R2
        ex(OP_OR, 4, 5, 0),      cn(4, 8'hFC, 16'h0000, 2),   // R2
        ex(OP_LDI, 6, 0, 8'h81), ex(OP_SHF, 6, 0, 8'h01),
        cn(6, 8'h02, 16'h0000, 3),                            // R3 left
        ex(OP_LDI, 6, 0, 8'h81), ex(OP_SHF, 6, 0, 8'h0B),
        cn(6, 8'h10, 16'h0000, 3),                            // R3 right
        ex(OP_LDI, 1, 0, 8'hFF), ex(OP_LDI, 2, 0, 8'hFF),
        ex(OP_MAC, 1, 2, 0),     ex(OP_MAC, 1, 2, 0),
        ex(OP_MVH, 7, 0, 0),     cn(7, 8'hFC, 16'hFC02, 4),   // R4
        ex(OP_MVL, 7, 0, 0),     cn(7, 8'h02, 16'hFC02, 4),   // R4
        ex(OP_MCLR, 0, 0, 0),    cn(7, 8'h02, 16'h0000, 4),   // R4
        ex(OP_LDI, 1, 0, 8'h5A), ex(OP_ST, 0, 1, 8'h3F),
        ex(OP_LD, 2, 0, 8'h3F),  cn(2, 8'h5A, 16'h0000, 5),   // R5
        ex(OP_ST, 0, 1, 8'h40),  ex(OP_LD, 3, 0, 8'h40),
        cn(3, 8'h00, 16'h0000, 5),                            // R5 out of range
        ex(OP_LDI, 3, 0, 8'h99), ex(OP_ST, 0, 1, 8'h80),
        ex(OP_LD, 3, 0, 8'h00),  cn(3, 8'h00, 16'h0000, 5),   // R5 no alias
        ex(OP_NRD, 4, 0, 0),     cn(4, 8'h11, 16'h0000, 6),   // R6
        ex(OP_NRD, 4, 0, 1),     cn(4, 8'h22, 16'h0000, 6),   // R6
        ex(OP_NRD, 4, 0, 2),     cn(4, 8'h00, 16'h0000, 6),   // R6 edge
        ex(OP_NRD, 4, 0, 3),     cn(4, 8'h44, 16'h0000, 6)    // R6
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [IW-1:0] instr = '0;
    logic [127:0]  det_data = '0;
    logic [3:0]    nbr_present = 4'b0000;
    logic [7:0]    nbr_n_in = '0, nbr_e_in = '0, nbr_w_in = '0, nbr_s_in = '0;
    logic [7:0]    news_out;
    logic [15:0]   acc_out;
    logic          busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    simd_pixel_node i_simd_pixel_node (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .det_data(det_data), .nbr_present(nbr_present),
        .nbr_n_in(nbr_n_in), .nbr_e_in(nbr_e_in), .nbr_w_in(nbr_w_in), .nbr_s_in(nbr_s_in),
        .news_out(news_out), .acc_out(acc_out), .busy(busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [IW-1:0] ins);
        @(negedge clk);
        instr_valid = v;
        instr       = ins;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] orig(int ch);
        return 8'h20 + 8'(ch * 7);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 news_out", 32'(news_out), 0);
        check("R10 acc_out", 32'(acc_out), 0);
        check("R10 busy", 32'(busy), 0);
        step(1'b1, mk(OP_LD, 1, 0, 8'h05));
        step(1'b1, mk(OP_NWR, 0, 1, 0));
        check("R10 memory word 5", 32'(news_out), 0);
        step(1'b1, mk(OP_NWR, 0, 7, 0));
        check("R10 register r7", 32'(news_out), 0);

        nbr_n_in = 8'h11; nbr_e_in = 8'h22; nbr_w_in = 8'h33; nbr_s_in = 8'h44;
        nbr_present = 4'b1011;

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i].ins);
            if (VEC[i].chk) begin
                check($sformatf("R%0d news_out vec %0d", VEC[i].req, i), 32'(news_out), 32'(VEC[i].en));
                check($sformatf("R%0d acc_out vec %0d", VEC[i].req, i), 32'(acc_out), 32'(VEC[i].ea));
            end
        end

        // R11 idle instructions have no effect
        step(1'b1, mk(OP_LDI, 1, 0, 3));
        step(1'b1, mk(OP_LDI, 2, 0, 4));
        step(1'b1, mk(OP_MAC, 1, 2, 0));
        step(1'b1, mk(OP_NWR, 0, 1, 0));
        step(1'b0, mk(OP_MCLR, 0, 0, 0));
        step(1'b0, mk(OP_NWR, 0, 2, 0));
        check("R11 acc held", 32'(acc_out), 32'h000C);
        check("R11 news_out held", 32'(news_out), 32'h03);
        step(1'b0, mk(OP_SMP, 0, 0, 0));
        check("R11 no capture", 32'(busy), 0);

        // R7 capture, R8 repeat ignored, R9 collision
        for (int ch = 0; ch < 16; ch++) det_data[ch*8 +: 8] = orig(ch);
        step(1'b1, mk(OP_SMP, 0, 0, 0));
        check("R7 busy after capture edge", 32'(busy), 1);
        det_data = {16{8'hEE}};
        for (int k = 1; k <= 16; k++) begin
            if (k == 2)       step(1'b1, mk(OP_LDI, 5, 0, 8'h77));
            else if (k == 5)  step(1'b1, mk(OP_SMP, 0, 0, 0));
            else if (k == 11) step(1'b1, mk(OP_ST, 0, 5, 8'h0A));
            else              step(1'b0, '0);
            if (k == 5)
                check("R8 busy unchanged by repeat capture", 32'(busy), 1);
            else
                check($sformatf("R7 busy after copy edge %0d", k), 32'(busy), (k <= 15) ? 1 : 0);
        end
        for (int w = 0; w < 17; w++) begin
            step(1'b1, mk(OP_LD, 6, 0, w));
            step(1'b1, mk(OP_NWR, 0, 6, 0));
            if (w == 10)
                check("R9 store wins over copy word 10", 32'(news_out), 32'h77);
            else if (w == 16)
                check("R7 word 16 untouched", 32'(news_out), 0);
            else
                check($sformatf("R7 R8 word %0d", w), 32'(news_out), 32'(orig(w)));
        end

        finish_run();
    end
endmodule